// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Tracker

This block watches the command strobes and the clock-enable line that a memory controller drives toward a DDR3-style device. It rebuilds the device's power state from the controller side. On every rising clock edge it registers CKE next to the CKE value from the previous edge. It reads the pair of levels together with the decoded command. It then moves a state register among the activity states (idle, bank active, reading, writing, precharging, refreshing) and the low-power states (active power-down, precharge power-down, self refresh).

The controller supplies five activity hint bits, which name its own bank, burst and refresh activity. While CKE stays high, the activity state follows these hints. When CKE falls, the state held before that edge selects which power-down the device enters. A combination of CKE levels and command that the rules do not allow raises a one-cycle illegal pulse and leaves the state unchanged. A separate checker counts the consecutive edges at which CKE has held its level. A toggle that comes too early raises a one-cycle pulse and steps a saturating violation counter.

Top module: `cke_power_tracker`

## Requirements
- R1: While rst_n is low the outputs read state 0 (idle), illegal_o 0, tcke_viol_o 0 and viol_cnt_o 0, and the stored previous CKE is high. The first low CKE sampled after reset is therefore treated as a falling edge.
- R2: Commands are decoded as follows. Deselect is cs_n=1. No-operation is cs_n=0 with ras_n, cas_n and we_n all 1. Refresh is cs_n=0, ras_n=0, cas_n=0 and we_n=1. Every other strobe pattern is an "other" command.
- R3: With CKE high at both edges and the state not a low-power state, the next state follows the hints in this priority order: hint_rd gives reading (2), hint_wr gives writing (3), hint_pre gives precharging (4), hint_ref gives refreshing (5), hint_act gives bank active (1), and no hint gives idle (0).
- R4: With CKE low at both edges and the state a low-power state (6, 7 or 8), the state is kept whatever the command, and no illegal pulse is raised.
- R5: A high-to-low CKE edge with deselect or no-operation goes to active power-down (6) from bank active, reading or writing. It goes to precharge power-down (7) from idle, precharging or refreshing.
- R6: A high-to-low CKE edge with a refresh command goes to self refresh (8) from idle only. From any other state it is illegal.
- R7: A low-to-high CKE edge with deselect or no-operation leaves active power-down for bank active (1), and leaves precharge power-down or self refresh for idle (0).
- R8: Every combination not covered by R3 to R7 counts as illegal. That includes a CKE edge with an "other" command, CKE low-low or low-to-high outside a low-power state, and CKE high-high inside one. An illegal combination sets illegal_o for exactly the cycle after the edge and keeps the state.
- R9: After each CKE toggle, CKE must be registered at its new level on TCKE_MIN consecutive edges, the toggle edge included. A toggle at an edge before that count is reached sets tcke_viol_o for the following cycle and increments viol_cnt_o. The state decision at that edge still follows R3 to R8.
- R10: viol_cnt_o saturates at all ones and never decreases except at reset.
- R11: state_o always holds one of the nine codes 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cke | input | 1 | Clock-enable level driven to the device |
| cs_n | input | 1 | Chip-select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| hint_rd | input | 1 | A read burst is in progress |
| hint_wr | input | 1 | A write burst is in progress |
| hint_pre | input | 1 | A precharge is in progress |
| hint_ref | input | 1 | An auto refresh is in progress |
| hint_act | input | 1 | At least one bank is open |
| state_o | output | 4 | Current power state code (0 to 8) |
| illegal_o | output | 1 | One-cycle pulse for a forbidden CKE/command combination |
| tcke_viol_o | output | 1 | One-cycle pulse for a CKE minimum-hold violation |
| viol_cnt_o | output | CNT_W | Saturating count of hold violations |

## Verification
Saturating the violation counter is the hardest case to reach from the ports. It needs many CKE toggles at intervals shorter than TCKE_MIN. Each of those toggles also disturbs the power state, so most of them land on illegal combinations that leave the state stranded. The bench makes the counter small and drives a directed burst of toggles on every edge. Random stimulus then toggles CKE with a low probability, so that legal power-down entries and exits, which need long holds, also occur. A bench model follows both the state machine and the hold counter edge by edge.

// File: rtl/cke_trk_pkg.sv
`timescale 1ns/1ps
package cke_trk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_BANK_ACT = 4'd1,
    ST_READ     = 4'd2,
    ST_WRITE    = 4'd3,
    ST_PRECH    = 4'd4,
    ST_REFRESH  = 4'd5,
    ST_ACT_PD   = 4'd6,
    ST_PRE_PD   = 4'd7,
    ST_SELF_REF = 4'd8
  } pstate_e;

  typedef enum logic [1:0] {
    CMD_DES   = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_REF   = 2'd2,
    CMD_OTHER = 2'd3
  } cmd_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic pre;
    logic rfr;
    logic act;
  } hint_t;

  function automatic logic is_low_power(pstate_e s);
    return (s == ST_ACT_PD) || (s == ST_PRE_PD) || (s == ST_SELF_REF);
  endfunction

  function automatic logic keeps_rows_open(pstate_e s);
    return (s == ST_BANK_ACT) || (s == ST_READ) || (s == ST_WRITE);
  endfunction

endpackage

// File: rtl/cke_cmd_decode.sv
`timescale 1ns/1ps
module cke_cmd_decode
  import cke_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DES;
    end else if (ras_n && cas_n && we_n) begin
      cmd = CMD_NOP;
    end else if (!ras_n && !cas_n && we_n) begin
      cmd = CMD_REF;
    end else begin
      cmd = CMD_OTHER;
    end
  end

endmodule

// File: rtl/cke_hold_check.sv
`timescale 1ns/1ps
module cke_hold_check #(
  parameter int TCKE_MIN = 3,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  output logic             cke_hist,
  output logic             viol_pulse,
  output logic [CNT_W-1:0] viol_cnt
);

  localparam int HW = (TCKE_MIN < 2) ? 1 : $clog2(TCKE_MIN + 1);
  localparam logic [HW-1:0] LIMIT = HW'(TCKE_MIN);
  localparam logic [HW-1:0] ONE   = HW'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [HW-1:0]    hold_q, hold_nxt;
  logic             toggle, short_hold, viol_nxt;
  logic             cnt_en, hold_en;
  logic [CNT_W-1:0] cnt_nxt;

  assign toggle     = cke ^ cke_hist;
  assign short_hold = (hold_q < LIMIT);
  assign viol_nxt   = toggle && short_hold;

  always_comb begin
    hold_en  = toggle || short_hold;
    hold_nxt = toggle ? ONE : (hold_q + ONE);
  end

  always_comb begin
    cnt_en  = viol_nxt && (viol_cnt != CNT_MAX);
    cnt_nxt = viol_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_hist <= 1'b1;
    end else if (toggle) begin
      cke_hist <= cke;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= LIMIT;
    end else if (hold_en) begin
      hold_q <= hold_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
    end else begin
      viol_pulse <= viol_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_cnt <= '0;
    end else if (cnt_en) begin
      viol_cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/cke_state_next.sv
`timescale 1ns/1ps
module cke_state_next
  import cke_trk_pkg::*;
(
  input  pstate_e cur,
  input  logic    cke_prev,
  input  logic    cke_now,
  input  cmd_e    cmd,
  input  hint_t   hint,
  output pstate_e nxt,
  output logic    illegal
);

  logic    lp, quiet;
  pstate_e busy_st;

  assign lp    = is_low_power(cur);
  assign quiet = (cmd == CMD_DES) || (cmd == CMD_NOP);

  // Activity priority while the clock stays enabled
  always_comb begin
    if (hint.rd) begin
      busy_st = ST_READ;
    end else if (hint.wr) begin
      busy_st = ST_WRITE;
    end else if (hint.pre) begin
      busy_st = ST_PRECH;
    end else if (hint.rfr) begin
      busy_st = ST_REFRESH;
    end else if (hint.act) begin
      busy_st = ST_BANK_ACT;
    end else begin
      busy_st = ST_IDLE;
    end
  end

  always_comb begin
    nxt     = cur;
    illegal = 1'b0;
    unique case ({cke_prev, cke_now})
      2'b11: begin
        if (lp) illegal = 1'b1;
        else    nxt = busy_st;
      end
      2'b00: begin
        if (!lp) illegal = 1'b1;
      end
      2'b01: begin
        if (lp && quiet) begin
          nxt = (cur == ST_ACT_PD) ? ST_BANK_ACT : ST_IDLE;
        end else begin
          illegal = 1'b1;
        end
      end
      2'b10: begin
        if (quiet && !lp) begin
          nxt = keeps_rows_open(cur) ? ST_ACT_PD : ST_PRE_PD;
        end else if ((cmd == CMD_REF) && (cur == ST_IDLE)) begin
          nxt = ST_SELF_REF;
        end else begin
          illegal = 1'b1;
        end
      end
      default: begin
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cke_power_tracker.sv
`timescale 1ns/1ps
module cke_power_tracker
  import cke_trk_pkg::*;
#(
  parameter int TCKE_MIN = 3,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             hint_rd,
  input  logic             hint_wr,
  input  logic             hint_pre,
  input  logic             hint_ref,
  input  logic             hint_act,
  output logic [3:0]       state_o,
  output logic             illegal_o,
  output logic             tcke_viol_o,
  output logic [CNT_W-1:0] viol_cnt_o
);

  cmd_e    cmd;
  hint_t   hint;
  pstate_e state_q, state_nxt;
  logic    illegal_nxt, state_en;
  logic    cke_hist;

  assign hint = '{rd: hint_rd, wr: hint_wr, pre: hint_pre, rfr: hint_ref, act: hint_act};

  cke_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  cke_hold_check #(
    .TCKE_MIN (TCKE_MIN),
    .CNT_W    (CNT_W)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cke_hist   (cke_hist),
    .viol_pulse (tcke_viol_o),
    .viol_cnt   (viol_cnt_o)
  );

  cke_state_next u_next (
    .cur      (state_q),
    .cke_prev (cke_hist),
    .cke_now  (cke),
    .cmd      (cmd),
    .hint     (hint),
    .nxt      (state_nxt),
    .illegal  (illegal_nxt)
  );

  assign state_en = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= illegal_nxt;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/cke_power_tracker_chk.sv
`timescale 1ns/1ps
module cke_power_tracker_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cke_hist,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [3:0]       state_o,
  input logic             illegal_o,
  input logic             tcke_viol_o,
  input logic [CNT_W-1:0] viol_cnt_o
);

  logic quiet_cmd, ref_cmd, in_lp;
  assign quiet_cmd = cs_n || (ras_n && cas_n && we_n);
  assign ref_cmd   = !cs_n && !ras_n && !cas_n && we_n;
  assign in_lp     = (state_o >= 4'd6) && (state_o <= 4'd8);

  // R4
  ll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_hist && !cke && in_lp) |=> ($stable(state_o) && !illegal_o));

  // R6
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_hist && !cke && ref_cmd && state_o == 4'd0) |=> (state_o == 4'd8));

  // R7
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_hist && cke && quiet_cmd && state_o == 4'd8) |=> (state_o == 4'd0 && !illegal_o));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (state_o == $past(state_o)));

  // R9
  viol_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tcke_viol_o && ($past(viol_cnt_o) != {CNT_W{1'b1}})) |-> (viol_cnt_o == $past(viol_cnt_o) + CNT_W'(1)));

  // R10
  cnt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tcke_viol_o |-> $stable(viol_cnt_o));

  // R11
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 4'd8);

endmodule

bind cke_power_tracker cke_power_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cke         (cke),
  .cke_hist    (cke_hist),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .state_o     (state_o),
  .illegal_o   (illegal_o),
  .tcke_viol_o (tcke_viol_o),
  .viol_cnt_o  (viol_cnt_o)
);

// File: tb/cke_power_tracker_test.sv
`timescale 1ns/1ps
module cke_power_tracker_test;

  localparam int TCK = 3;
  localparam int CW  = 3;
  localparam int CMAX = (1 << CW) - 1;

  // strobe patterns {cs_n, ras_n, cas_n, we_n} (R2)
  localparam logic [3:0] S_DES = 4'b1111;
  localparam logic [3:0] S_NOP = 4'b0111;
  localparam logic [3:0] S_REF = 4'b0001;
  localparam logic [3:0] S_OTH = 4'b0100;
  // hint vectors {rd, wr, pre, ref, act}
  localparam logic [4:0] H_NONE = 5'b00000;
  localparam logic [4:0] H_ACT  = 5'b00001;
  localparam logic [4:0] H_RFR  = 5'b00010;
  localparam logic [4:0] H_PRE  = 5'b00100;
  localparam logic [4:0] H_WR   = 5'b01000;
  localparam logic [4:0] H_RD   = 5'b10000;

  logic clk = 1'b0;
  logic rst_n;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic hint_rd, hint_wr, hint_pre, hint_ref, hint_act;
  logic [3:0]    state_o;
  logic          illegal_o, tcke_viol_o;
  logic [CW-1:0] viol_cnt_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int m_state, m_hold, m_vcnt;
  bit m_ckeq, e_ill, e_viol;

  always #4 clk = ~clk;

  cke_power_tracker #(.TCKE_MIN(TCK), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .hint_rd(hint_rd), .hint_wr(hint_wr),
    .hint_pre(hint_pre), .hint_ref(hint_ref), .hint_act(hint_act),
    .state_o(state_o), .illegal_o(illegal_o), .tcke_viol_o(tcke_viol_o),
    .viol_cnt_o(viol_cnt_o)
  );

  function automatic int cmd_of(logic [3:0] s);
    if (s[3]) return 0;
    if (s[2:0] == 3'b111) return 1;
    if (s[2:0] == 3'b001) return 2;
    return 3;
  endfunction

  function automatic int busy_of(logic [4:0] h);
    if (h[4]) return 2;
    if (h[3]) return 3;
    if (h[2]) return 4;
    if (h[1]) return 5;
    if (h[0]) return 1;
    return 0;
  endfunction

  function automatic int next_of(int cur, bit pc, bit nc, int cmd, logic [4:0] h, output bit ill);
    bit lp = (cur >= 6);
    bit q = (cmd < 2);
    ill = 0;
    if (pc && nc) begin
      if (lp) begin ill = 1; return cur; end
      return busy_of(h);
    end else if (!pc && !nc) begin
      if (!lp) ill = 1;
      return cur;
    end else if (!pc && nc) begin
      if (lp && q) return (cur == 6) ? 1 : 0;
      ill = 1; return cur;
    end else begin
      if (q && !lp) return (cur >= 1 && cur <= 3) ? 6 : 7;
      if (cmd == 2 && cur == 0) return 8;
      ill = 1; return cur;
    end
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit c, logic [3:0] s, logic [4:0] h, string tag);
    int cmd;
    bit tog;
    @(negedge clk);
    cke = c; {cs_n, ras_n, cas_n, we_n} = s;
    {hint_rd, hint_wr, hint_pre, hint_ref, hint_act} = h;
    cmd = cmd_of(s);
    m_state = next_of(m_state, m_ckeq, c, cmd, h, e_ill);
    tog = (c != m_ckeq);
    e_viol = tog && (m_hold < TCK);
    m_hold = tog ? 1 : ((m_hold < TCK) ? m_hold + 1 : m_hold);
    if (e_viol && m_vcnt < CMAX) m_vcnt++;
    m_ckeq = c;
    @(posedge clk);
    #1;
    chk(tag, "state", int'(state_o), m_state);
    chk(tag, "illegal", int'(illegal_o), int'(e_ill));
    chk(tag, "tcke_viol", int'(tcke_viol_o), int'(e_viol));
    chk(tag, "viol_cnt", int'(viol_cnt_o), m_vcnt);
  endtask

  task automatic hold(int n, bit c, logic [3:0] s, logic [4:0] h, string tag);
    for (int i = 0; i < n; i++) step(c, s, h, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = S_DES;
    {hint_rd, hint_wr, hint_pre, hint_ref, hint_act} = H_NONE;
    m_state = 0; m_hold = TCK; m_vcnt = 0; m_ckeq = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1", "state", int'(state_o), 0);
    chk("R1", "illegal", int'(illegal_o), 0);
    chk("R1", "tcke_viol", int'(tcke_viol_o), 0);
    chk("R1", "viol_cnt", int'(viol_cnt_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: history high so first low is an entry; R5 precharge power-down from idle
    step(0, S_NOP, H_NONE, "R1");
    // R4: any command while held low
    step(0, S_OTH, H_NONE, "R4");
    step(0, S_REF, H_RD, "R4");
    // R7 exit to idle
    step(1, S_DES, H_NONE, "R7");
    // R3 hint priority, R2 commands irrelevant while high
    step(1, S_OTH, H_RD | H_ACT, "R3");
    step(1, S_NOP, H_WR | H_PRE, "R3");
    step(1, S_REF, H_PRE | H_RFR, "R3");
    step(1, S_DES, H_RFR | H_ACT, "R3");
    step(1, S_NOP, H_ACT, "R3");
    // R5 active power-down from bank active, R7 exit to bank active
    step(0, S_DES, H_ACT, "R5");
    hold(2, 0, S_OTH, H_NONE, "R4");
    step(1, S_NOP, H_NONE, "R7");
    // R5 from writing
    hold(2, 1, S_NOP, H_WR, "R3");
    step(0, S_NOP, H_NONE, "R5");
    hold(2, 0, S_DES, H_NONE, "R4");
    step(1, S_DES, H_NONE, "R7");
    // R5 from precharging -> precharge power-down
    hold(2, 1, S_NOP, H_PRE, "R3");
    step(0, S_DES, H_NONE, "R5");
    hold(2, 0, S_NOP, H_NONE, "R4");
    step(1, S_NOP, H_NONE, "R7");
    // R6 self refresh from idle, R7 exit
    hold(2, 1, S_NOP, H_NONE, "R3");
    step(0, S_REF, H_NONE, "R6");
    hold(4, 0, S_OTH, H_ACT, "R4");
    step(1, S_NOP, H_NONE, "R7");
    // R6 refresh on falling edge from bank active is illegal
    hold(2, 1, S_NOP, H_ACT, "R3");
    step(0, S_REF, H_ACT, "R6");
    // R8 low-low outside low power, low-to-high outside low power
    hold(2, 0, S_NOP, H_NONE, "R8");
    step(1, S_NOP, H_NONE, "R8");
    hold(2, 1, S_NOP, H_NONE, "R3");
    // R8 falling edge with other command
    step(0, S_OTH, H_NONE, "R8");
    hold(2, 0, S_NOP, H_NONE, "R8");
    step(1, S_DES, H_NONE, "R8");
    hold(2, 1, S_NOP, H_NONE, "R3");
    // R9 early toggle after one low edge
    step(0, S_NOP, H_NONE, "R9");
    step(1, S_NOP, H_NONE, "R9");
    // R10 saturate counter with toggles on every edge
    for (int i = 0; i < 12; i++) step(i[0], S_NOP, H_NONE, "R10");
    hold(3, 1, S_NOP, H_NONE, "R10");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit c = m_ckeq;
      logic [3:0] s;
      int k;
      if (($urandom % 5) == 0) c = !c;
      k = $urandom % 4;
      s = (k == 0) ? S_DES : (k == 1) ? S_NOP : (k == 2) ? S_REF : 4'($urandom);
      step(c, s, 5'($urandom), "R8");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule